// File: doc/BRIEF.md
# Host Receive Register Read Port

This block holds one 24-bit word that travels from the device core towards an external host. The core offers a word with a valid strobe. The word is taken only while the holder is empty, and taking it raises a receive-ready flag. The host collects the word through one of two bus personalities, chosen by a mode field.

The first personality is a PCI-style memory target. It has a 64 KiB window that is selected by the upper address half. It drives all four byte lanes and ignores the byte enables. If data is late it holds the read with a bounded run of wait cycles, and if data is still missing at the end it terminates the read with a retry. The second personality is a generic bus. Its address decode uses a small base field and a fixed register select. A read that finds the holder empty waits for as long as it takes.

A 2-bit format field chooses what the host sees: the whole 24-bit word, or a 16-bit half of it. A request status bit and two active-low request pins tell the host that data is waiting. A hardware reset or either of two software flush pulses empties the holder.

Top module: `hrx_read_port`

## Requirements
- R1: In PCI mode (mode code 2'b01), a read is claimed only when address bits [31:16] equal the configured window base and the offset in bits [15:0] lies in 0x001C to 0xFFFC inclusive. Any other address gets no acknowledge, no wait and no retry, and the held word stays in place.
- R2: A PCI read that completes returns the formatted word on all 32 data bits, with bits above the data zero-filled, whatever the byte-enable input is. Format 0 gives {8'h00, word}. Format 1 gives {16'h0000, word[23:8]}. Formats 2 and 3 give {16'h0000, word[15:0]}.
- R3: In generic mode (mode code 2'b10 or 2'b11), a read is claimed only when address bits [10:3] equal the configured generic base and bits [2:0] equal 3'b111. Other addresses get no response.
- R4: A generic read with format 0 returns all three bytes of the word on data bits [23:0].
- R5: A generic read with a nonzero format returns 16 bits on data bits [15:0], with bits [23:16] zero. Format 1 selects word[23:8]. Formats 2 and 3 select word[15:0].
- R6: Request status is high when receive-ready and the request enable are both set. In generic mode it drives irq_n low when DMA is disabled and dreq_n low when DMA is enabled. In PCI mode, or with status low, both pins stay high.
- R7: In PCI mode, with wait-disable clear and the holder empty, the target asserts pci_wait for up to 8 cycles. If data arrives in that time the read ends with an acknowledge carrying that data. Otherwise pci_retry pulses for one cycle right after the 8th wait cycle.
- R8: In PCI mode, with wait-disable set and the holder empty, the read ends with a retry and no wait cycles.
- R9: In generic mode, a read of an empty holder keeps gb_wait high with no time limit. It ends with an acknowledge carrying the word once the core supplies one.
- R10: A hardware reset, or a one-cycle pulse on either software flush input, empties the holder, and rx_rdy reads 0 on the next cycle.
- R11: A core word is accepted only when the holder is empty. A word offered while the holder is full is dropped. A completed read clears rx_rdy, and a retry consumes nothing. Acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_flush_host | input | 1 | Host-issued software flush pulse |
| sw_flush_core | input | 1 | Core-issued software flush pulse |
| cfg_mode | input | 2 | 00 off, 01 PCI target, 1x generic bus |
| cfg_fmt | input | 2 | Data alignment select |
| cfg_req_en | input | 1 | Receive request enable |
| cfg_dma_en | input | 1 | Steer request to the DMA pin instead of the interrupt pin |
| cfg_wait_dis | input | 1 | PCI: retry at once instead of waiting |
| cfg_pci_base | input | 16 | PCI window base (address bits 31:16) |
| cfg_gb_base | input | 8 | Generic bus base (address bits 10:3) |
| core_word | input | 24 | Word from the core |
| core_valid | input | 1 | Core word strobe |
| rx_rdy | output | 1 | Holder full (receive-ready) |
| pci_rd | input | 1 | PCI read data phase request, held until ack or retry |
| pci_addr | input | 32 | PCI address |
| pci_be_n | input | 4 | PCI byte enables (ignored on reads of this register) |
| pci_data | output | 32 | PCI read data, valid with pci_ack |
| pci_wait | output | 1 | PCI target wait |
| pci_ack | output | 1 | PCI data phase complete |
| pci_retry | output | 1 | PCI retry termination |
| gb_rd | input | 1 | Generic read strobe, held until ack |
| gb_addr | input | 11 | Generic address |
| gb_data | output | 24 | Generic read data, valid with gb_ack |
| gb_wait | output | 1 | Generic wait |
| gb_ack | output | 1 | Generic read complete |
| req_stat | output | 1 | Request status bit |
| irq_n | output | 1 | Active-low interrupt request |
| dreq_n | output | 1 | Active-low DMA request |

## Verification
The assertions take the following for granted:
- The host keeps its read strobe high until it sees an acknowledge or a retry, and drops it before the next access starts.
- Only the strobe of the personality selected by cfg_mode is used.
- Configuration does not change in the middle of a read.
- Flush pulses are synchronous to the clock.

The bench drives every read from a single task that raises one strobe, holds it until the access terminates, and then drops it for several idle cycles. It changes mode, format and DMA steering only between accesses, so every sequence it produces stays inside those assumptions.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_PCI = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ACK   = 3'd2,
    ST_RETRY = 3'd3,
    ST_HOLD  = 3'd4
  } hrx_state_e;

endpackage

// File: rtl/hrx_rst_sync.sv
module hrx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hrx_decode.sv
module hrx_decode
  import hrx_pkg::*;
#(
  parameter int              PCI_AW    = 32,
  parameter int              WIN_W     = 16,
  parameter logic [15:0]     WIN_LO    = 16'h001C,
  parameter logic [15:0]     WIN_HI    = 16'hFFFC,
  parameter int              GB_BASE_W = 8,
  parameter int              GB_SEL_W  = 3,
  parameter logic [2:0]      GB_SEL    = 3'b111,
  localparam int             GB_AW     = GB_BASE_W + GB_SEL_W,
  localparam int             PB_W      = PCI_AW - WIN_W
) (
  input  logic [1:0]           cfg_mode,
  input  logic [PB_W-1:0]      cfg_pci_base,
  input  logic [GB_BASE_W-1:0] cfg_gb_base,
  input  logic [PCI_AW-1:0]    pci_addr,
  input  logic                 pci_rd,
  input  logic [GB_AW-1:0]     gb_addr,
  input  logic                 gb_rd,
  output logic                 pci_req,
  output logic                 gb_req
);

  logic [WIN_W-1:0] win_off;
  logic             pci_hit;
  logic             gb_hit;

  assign win_off = pci_addr[WIN_W-1:0];

  always_comb begin
    pci_hit = (cfg_mode == MODE_PCI)
           && (pci_addr[PCI_AW-1:WIN_W] == cfg_pci_base)
           && (win_off >= WIN_LO[WIN_W-1:0])
           && (win_off <= WIN_HI[WIN_W-1:0]);
    gb_hit  = cfg_mode[1]
           && (gb_addr[GB_AW-1:GB_SEL_W] == cfg_gb_base)
           && (gb_addr[GB_SEL_W-1:0] == GB_SEL[GB_SEL_W-1:0]);
  end

  assign pci_req = pci_hit && pci_rd;
  assign gb_req  = gb_hit && gb_rd;

endmodule

// File: rtl/hrx_hold.sv
module hrx_hold #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic [DATA_W-1:0] core_word,
  input  logic              core_valid,
  output logic              full_q,
  output logic [DATA_W-1:0] word_q
);

  logic              full_d;
  logic              load;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    load   = core_valid && !full_q && !flush;
    full_d = full_q;
    word_d = word_q;
    if (flush || take) begin
      full_d = 1'b0;
    end else if (load) begin
      full_d = 1'b1;
    end
    if (load) begin
      word_d = core_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= full_d;
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/hrx_fsm.sv
module hrx_fsm
  import hrx_pkg::*;
#(
  parameter int WAIT_LIMIT = 8,
  localparam int CNT_W     = $clog2(WAIT_LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pci_req,
  input  logic       gb_req,
  input  logic       pci_rd,
  input  logic       gb_rd,
  input  logic       full,
  input  logic       wait_dis,
  output hrx_state_e state_q,
  output logic       sel_pci_q,
  output logic       take
);

  hrx_state_e       state_d;
  logic             sel_pci_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             live;

  assign live = sel_pci_q ? pci_rd : gb_rd;

  always_comb begin
    state_d   = state_q;
    sel_pci_d = sel_pci_q;
    cnt_d     = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (pci_req || gb_req) begin
          sel_pci_d = pci_req;
          if (full) begin
            state_d = ST_ACK;
          end else if (pci_req && wait_dis) begin
            state_d = ST_RETRY;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = CNT_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (!live) begin
          state_d = ST_IDLE;
        end else if (full) begin
          state_d = ST_ACK;
        end else if (sel_pci_q && (cnt_q == CNT_W'(WAIT_LIMIT))) begin
          state_d = ST_RETRY;
        end else if (sel_pci_q) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ACK, ST_RETRY: begin
        state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!live) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign take = (state_d == ST_ACK) && (state_q != ST_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_pci_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_d;
      sel_pci_q <= sel_pci_d;
      cnt_q     <= cnt_d;
    end
  end

endmodule

// File: rtl/hrx_format.sv
module hrx_format #(
  parameter int DATA_W = 24,
  parameter int HALF_W = 16,
  parameter int OUT_W  = 32
) (
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] word,
  output logic [OUT_W-1:0]  lanes
);

  always_comb begin
    case (fmt)
      2'd0:    lanes = OUT_W'(word);
      2'd1:    lanes = OUT_W'(word[DATA_W-1 -: HALF_W]);
      default: lanes = OUT_W'(word[HALF_W-1:0]);
    endcase
  end

endmodule

// File: rtl/hrx_read_port.sv
module hrx_read_port
  import hrx_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int HALF_W     = 16,
  parameter int PCI_DW     = 32,
  parameter int PCI_AW     = 32,
  parameter int WIN_W      = 16,
  parameter int GB_BASE_W  = 8,
  parameter int GB_SEL_W   = 3,
  parameter int WAIT_LIMIT = 8,
  localparam int GB_AW     = GB_BASE_W + GB_SEL_W,
  localparam int PB_W      = PCI_AW - WIN_W,
  localparam int BE_W      = PCI_DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_flush_host,
  input  logic                 sw_flush_core,
  input  logic [1:0]           cfg_mode,
  input  logic [1:0]           cfg_fmt,
  input  logic                 cfg_req_en,
  input  logic                 cfg_dma_en,
  input  logic                 cfg_wait_dis,
  input  logic [PB_W-1:0]      cfg_pci_base,
  input  logic [GB_BASE_W-1:0] cfg_gb_base,
  input  logic [DATA_W-1:0]    core_word,
  input  logic                 core_valid,
  output logic                 rx_rdy,
  input  logic                 pci_rd,
  input  logic [PCI_AW-1:0]    pci_addr,
  input  logic [BE_W-1:0]      pci_be_n,
  output logic [PCI_DW-1:0]    pci_data,
  output logic                 pci_wait,
  output logic                 pci_ack,
  output logic                 pci_retry,
  input  logic                 gb_rd,
  input  logic [GB_AW-1:0]     gb_addr,
  output logic [DATA_W-1:0]    gb_data,
  output logic                 gb_wait,
  output logic                 gb_ack,
  output logic                 req_stat,
  output logic                 irq_n,
  output logic                 dreq_n
);

  logic              rst_i_n;
  logic              pci_req;
  logic              gb_req;
  logic              full;
  logic [DATA_W-1:0] word;
  hrx_state_e        state;
  logic              sel_pci;
  logic              take;
  logic [PCI_DW-1:0] lanes;
  logic [PCI_DW-1:0] out_q;
  logic [PCI_DW-1:0] out_d;
  logic              unused_be;
  logic              gb_mode;

  // Byte enables never gate read lanes for this register.
  assign unused_be = ^pci_be_n;

  hrx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  hrx_decode #(
    .PCI_AW    (PCI_AW),
    .WIN_W     (WIN_W),
    .GB_BASE_W (GB_BASE_W),
    .GB_SEL_W  (GB_SEL_W)
  ) u_dec (
    .cfg_mode     (cfg_mode),
    .cfg_pci_base (cfg_pci_base),
    .cfg_gb_base  (cfg_gb_base),
    .pci_addr     (pci_addr),
    .pci_rd       (pci_rd),
    .gb_addr      (gb_addr),
    .gb_rd        (gb_rd),
    .pci_req      (pci_req),
    .gb_req       (gb_req)
  );

  // Hardware reset acts asynchronously on the holder; flushes act on the edge.
  hrx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (sw_flush_host || sw_flush_core || !rst_i_n),
    .take       (take),
    .core_word  (core_word),
    .core_valid (core_valid),
    .full_q     (full),
    .word_q     (word)
  );

  hrx_fsm #(.WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pci_req   (pci_req),
    .gb_req    (gb_req),
    .pci_rd    (pci_rd),
    .gb_rd     (gb_rd),
    .full      (full),
    .wait_dis  (cfg_wait_dis),
    .state_q   (state),
    .sel_pci_q (sel_pci),
    .take      (take)
  );

  hrx_format #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W),
    .OUT_W  (PCI_DW)
  ) u_fmt (
    .fmt   (cfg_fmt),
    .word  (word),
    .lanes (lanes)
  );

  // Read data is captured at the consuming edge so it stays stable while acked.
  always_comb begin
    out_d = out_q;
    if (take) out_d = lanes;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_q <= '0;
    else          out_q <= out_d;
  end

  assign pci_ack   = (state == ST_ACK) && sel_pci;
  assign gb_ack    = (state == ST_ACK) && !sel_pci;
  assign pci_retry = (state == ST_RETRY);
  assign pci_wait  = (state == ST_WAIT) && sel_pci;
  assign gb_wait   = (state == ST_WAIT) && !sel_pci;
  assign pci_data  = pci_ack ? out_q : '0;
  assign gb_data   = gb_ack ? out_q[DATA_W-1:0] : '0;

  assign rx_rdy   = full;
  assign gb_mode  = cfg_mode[1];
  assign req_stat = full && cfg_req_en;
  assign irq_n    = !(req_stat && gb_mode && !cfg_dma_en);
  assign dreq_n   = !(req_stat && gb_mode && cfg_dma_en);

endmodule

// File: rtl/hrx_read_port_chk.sv
module hrx_read_port_chk #(
  parameter int WAIT_LIMIT = 8,
  localparam int WC_W      = $clog2(WAIT_LIMIT + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic sw_flush_host,
  input logic sw_flush_core,
  input logic rx_rdy,
  input logic req_stat,
  input logic pci_wait,
  input logic pci_ack,
  input logic pci_retry,
  input logic gb_ack,
  input logic irq_n,
  input logic dreq_n
);

  logic [WC_W-1:0] wrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wrun_q <= '0;
    else if (!pci_wait)                   wrun_q <= '0;
    else if (wrun_q != WC_W'(WAIT_LIMIT + 1)) wrun_q <= wrun_q + WC_W'(1);
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pci_wait |-> (wrun_q < WC_W'(WAIT_LIMIT))); // R7
  AST_RETRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(pci_retry) |-> $past(!rx_rdy)); // R8
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!irq_n && !dreq_n)); // R6
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!irq_n || !dreq_n) |-> (rx_rdy && req_stat)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (sw_flush_host || sw_flush_core) |=> !rx_rdy); // R10
  AST_RDY_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_rdy) |-> (pci_ack || gb_ack || $past(sw_flush_host) || $past(sw_flush_core))); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (pci_ack || gb_ack) |=> !(pci_ack || gb_ack)); // R11
  AST_ACK_HAD_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(pci_ack || gb_ack) |-> $past(rx_rdy)); // R9

endmodule

bind hrx_read_port hrx_read_port_chk #(.WAIT_LIMIT(WAIT_LIMIT)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_flush_host (sw_flush_host),
  .sw_flush_core (sw_flush_core),
  .rx_rdy        (rx_rdy),
  .req_stat      (req_stat),
  .pci_wait      (pci_wait),
  .pci_ack       (pci_ack),
  .pci_retry     (pci_retry),
  .gb_ack        (gb_ack),
  .irq_n         (irq_n),
  .dreq_n        (dreq_n)
);

// File: tb/test_hrx_read_port.sv
module test_hrx_read_port;

  logic        clk;
  logic        rst_n;
  logic        sw_flush_host, sw_flush_core;
  logic [1:0]  cfg_mode, cfg_fmt;
  logic        cfg_req_en, cfg_dma_en, cfg_wait_dis;
  logic [15:0] cfg_pci_base;
  logic [7:0]  cfg_gb_base;
  logic [23:0] core_word;
  logic        core_valid;
  logic        rx_rdy;
  logic        pci_rd;
  logic [31:0] pci_addr;
  logic [3:0]  pci_be_n;
  logic [31:0] pci_data;
  logic        pci_wait, pci_ack, pci_retry;
  logic        gb_rd;
  logic [10:0] gb_addr;
  logic [23:0] gb_data;
  logic        gb_wait, gb_ack;
  logic        req_stat, irq_n, dreq_n;

  int n_chk = 0;
  int n_bad = 0;

  hrx_read_port i_hrx_read_port (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [15:0] PBASE = 16'hC0DE;
  localparam logic [7:0]  GBASE = 8'h5A;

  // {is_pci, fmt, word, expected read data}
  localparam int NV = 8;
  localparam logic [58:0] VEC [NV] = '{
    {1'b1, 2'd0, 24'hA1B2C3, 32'h00A1B2C3},
    {1'b1, 2'd1, 24'hA1B2C3, 32'h0000A1B2},
    {1'b1, 2'd2, 24'hA1B2C3, 32'h0000B2C3},
    {1'b1, 2'd3, 24'h123456, 32'h00003456},
    {1'b0, 2'd0, 24'hFEDCBA, 32'h00FEDCBA},
    {1'b0, 2'd1, 24'hFEDCBA, 32'h0000FEDC},
    {1'b0, 2'd2, 24'hFEDCBA, 32'h0000DCBA},
    {1'b0, 2'd3, 24'h0F1E2D, 32'h00001E2D}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic load(input logic [23:0] w);
    @(negedge clk);
    core_word  = w;
    core_valid = 1'b1;
    @(negedge clk);
    core_valid = 1'b0;
  endtask

  task automatic do_read(input bit use_pci, input logic [31:0] addr, input int max_cyc,
                         input int load_at, input logic [23:0] load_word,
                         output bit acked, output bit retried, output int nwait,
                         output logic [31:0] data);
    acked = 1'b0; retried = 1'b0; nwait = 0; data = '0;
    @(negedge clk);
    if (use_pci) begin pci_addr = addr; pci_rd = 1'b1; end
    else begin gb_addr = addr[10:0]; gb_rd = 1'b1; end
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      core_valid = 1'b0;
      if (pci_ack || gb_ack) begin
        acked = 1'b1;
        data  = use_pci ? pci_data : {8'h00, gb_data};
        break;
      end
      if (pci_retry) begin retried = 1'b1; break; end
      if (pci_wait || gb_wait) nwait++;
      if (i == load_at) begin core_word = load_word; core_valid = 1'b1; end
    end
    core_valid = 1'b0;
    pci_rd = 1'b0;
    gb_rd  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    bit acked, retried;
    int nwait;
    logic [31:0] data;
    string tag;

    rst_n = 1'b0; sw_flush_host = 1'b0; sw_flush_core = 1'b0;
    cfg_mode = 2'b01; cfg_fmt = 2'd0; cfg_req_en = 1'b1; cfg_dma_en = 1'b0;
    cfg_wait_dis = 1'b0; cfg_pci_base = PBASE; cfg_gb_base = GBASE;
    core_word = '0; core_valid = 1'b0; pci_rd = 1'b0; pci_addr = '0; pci_be_n = '0;
    gb_rd = 1'b0; gb_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R10 reset rx_rdy", 32'(rx_rdy), 32'd0);
    chk("R11 reset acks", {30'd0, pci_ack, gb_ack}, 32'd0);
    chk("R6 reset request pins", {30'd0, irq_n, dreq_n}, 32'd3);
    chk("R7 reset wait/retry", {29'd0, pci_wait, gb_wait, pci_retry}, 32'd0);

    // Vector table: formatting in both personalities
    for (int k = 0; k < NV; k++) begin
      logic        is_pci;
      logic [1:0]  fmt;
      logic [23:0] w;
      logic [31:0] exp;
      {is_pci, fmt, w, exp} = VEC[k];
      cfg_mode = is_pci ? 2'b01 : ((k % 2 == 0) ? 2'b10 : 2'b11);
      cfg_fmt  = fmt;
      pci_be_n = 4'(k * 5);
      tag = is_pci ? "R2" : ((fmt == 2'd0) ? "R4" : "R5");
      load(w);
      do_read(is_pci, is_pci ? {PBASE, 16'h0100} : {21'd0, GBASE, 3'b111},
              20, -1, '0, acked, retried, nwait, data);
      chk({tag, " ack"}, 32'(acked), 32'd1);
      chk({tag, " data"}, data, exp);
      chk("R11 read clears rx_rdy", 32'(rx_rdy), 32'd0);
    end

    // R1: PCI window edges and misses
    cfg_mode = 2'b01; cfg_fmt = 2'd0;
    load(24'h111111);
    do_read(1, {PBASE, 16'h0018}, 12, -1, '0, acked, retried, nwait, data);
    chk("R1 below window no ack", {30'd0, acked, retried}, 32'd0);
    chk("R1 below window no wait", 32'(nwait), 32'd0);
    chk("R1 below window keeps word", 32'(rx_rdy), 32'd1);
    do_read(1, {16'hC0DF, 16'h0100}, 12, -1, '0, acked, retried, nwait, data);
    chk("R1 wrong base no ack", {30'd0, acked, retried}, 32'd0);
    do_read(1, {PBASE, 16'h001C}, 12, -1, '0, acked, retried, nwait, data);
    chk("R1 low edge data", data, 32'h00111111);
    load(24'h222222);
    do_read(1, {PBASE, 16'hFFFC}, 12, -1, '0, acked, retried, nwait, data);
    chk("R1 high edge data", data, 32'h00222222);

    // R3: generic decode
    cfg_mode = 2'b10;
    load(24'h333333);
    do_read(0, {21'd0, GBASE, 3'b110}, 12, -1, '0, acked, retried, nwait, data);
    chk("R3 wrong select no ack", 32'(acked), 32'd0);
    do_read(0, {21'd0, 8'h5B, 3'b111}, 12, -1, '0, acked, retried, nwait, data);
    chk("R3 wrong base no ack", 32'(acked), 32'd0);
    chk("R3 miss keeps word", 32'(rx_rdy), 32'd1);

    // R6: request steering (word 0x333333 still held)
    cfg_dma_en = 1'b0; #1;
    chk("R6 irq path", {29'd0, req_stat, irq_n, dreq_n}, 32'b101);
    cfg_dma_en = 1'b1; #1;
    chk("R6 dma path", {29'd0, req_stat, irq_n, dreq_n}, 32'b110);
    cfg_req_en = 1'b0; #1;
    chk("R6 disabled", {29'd0, req_stat, irq_n, dreq_n}, 32'b011);
    cfg_req_en = 1'b1; cfg_mode = 2'b01; #1;
    chk("R6 pci mode pins idle", {29'd0, req_stat, irq_n, dreq_n}, 32'b111);
    cfg_dma_en = 1'b0;

    // R11: second word dropped while full
    load(24'h444444);
    do_read(1, {PBASE, 16'h0200}, 12, -1, '0, acked, retried, nwait, data);
    chk("R11 full drops new word", data, 32'h00333333);

    // R7: bounded wait then retry; nothing consumed
    do_read(1, {PBASE, 16'h0200}, 30, -1, '0, acked, retried, nwait, data);
    chk("R7 retry after waits", {30'd0, acked, retried}, 32'd1);
    chk("R7 wait count", 32'(nwait), 32'd8);
    chk("R11 retry leaves empty", 32'(rx_rdy), 32'd0);
    // R7: data during wait completes the read
    do_read(1, {PBASE, 16'h0200}, 30, 3, 24'h555555, acked, retried, nwait, data);
    chk("R7 late data ack", {30'd0, acked, retried}, 32'd2);
    chk("R7 late data value", data, 32'h00555555);

    // R8: wait disabled
    cfg_wait_dis = 1'b1;
    do_read(1, {PBASE, 16'h0200}, 30, -1, '0, acked, retried, nwait, data);
    chk("R8 immediate retry", {30'd0, acked, retried}, 32'd1);
    chk("R8 no waits", 32'(nwait), 32'd0);
    cfg_wait_dis = 1'b0;

    // R9: generic unbounded wait
    cfg_mode = 2'b11;
    do_read(0, {21'd0, GBASE, 3'b111}, 60, 20, 24'h666666, acked, retried, nwait, data);
    chk("R9 long wait ack", {30'd0, acked, retried}, 32'd2);
    chk("R9 waited past limit", 32'(nwait >= 20), 32'd1);
    chk("R9 data", data, 32'h00666666);

    // R10: flushes and hardware reset
    load(24'h777777);
    @(negedge clk); sw_flush_host = 1'b1; @(negedge clk); sw_flush_host = 1'b0;
    chk("R10 host flush", 32'(rx_rdy), 32'd0);
    load(24'h888888);
    @(negedge clk); sw_flush_core = 1'b1; @(negedge clk); sw_flush_core = 1'b0;
    chk("R10 core flush", 32'(rx_rdy), 32'd0);
    load(24'h999999);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 hw reset", 32'(rx_rdy), 32'd0);
    load(24'hABCDEF);
    cfg_fmt = 2'd0;
    do_read(0, {21'd0, GBASE, 3'b111}, 20, -1, '0, acked, retried, nwait, data);
    chk("R4 after reset data", data, 32'h00ABCDEF);

    summary();
    $finish;
  end

endmodule